// File: doc/BRIEF.md
# Video Memory Block-Copy Engine

This engine copies bytes from anywhere in the 16-bit address space into the video memory window. The copy moves in units of 16 bytes. Software loads four byte-wide pointer registers and then writes a control byte. That write selects the mode and gives the length as a unit count minus one.

In immediate mode the whole transfer runs back to back, and the CPU is held off for its full length. In line-gap mode the engine is armed. It then moves exactly one unit on each rising edge of the horizontal-blank input, and holds the CPU only while that unit moves. After every unit the advanced pointers go back into the pointer registers. The control byte then reads back the number of units still to go, with an inactive flag in the top bit.

The memory side is one byte-wide request channel with valid/ready handshakes. A request stays asserted, with its address, direction and write data unchanged, until the cycle in which `mem_ready` is high. A read completes in that same cycle, with `mem_rdata` valid. Every byte is one read followed by one write, so with `mem_ready` held high each byte costs two cycles.

Top module: `vram_copy_engine`

## Requirements
- R1: After reset, pointer registers 0–3 read 0x00, the control byte (index 4) reads 0xFF, `cpu_stall` is low and `mem_valid` is low.
- R2: The source is `{reg0, reg1}` with the 4 low bits cleared, and the first read of a transfer goes to that address.
- R3: If the aligned source lies in 0x8000–0x9FFF, a control write starts nothing, arms nothing and leaves the control byte unchanged.
- R4: The destination of each unit is `({reg2, reg3} & 0x1FF0) | 0x8000`. Every write address therefore lies in 0x8000–0x9FFF, and a unit that would pass 0x9FFF restarts at 0x8000.
- R5: A control write with bit 7 = 0 copies (bits[6:0]+1)×16 bytes in ascending address order, each written byte equal to the byte read. Afterwards the control byte reads 0xFF.
- R6: During an immediate transfer of N units with `mem_ready` held high, `cpu_stall` is high for exactly 33·N−1 cycles: two per byte, plus one between units.
- R7: After each unit, register 0 and register 1 hold the source address following the last byte read. Register 2 and register 3 hold the destination address following the last byte written.
- R8: A control write with bit 7 = 1 arms line-gap mode, and the control byte then reads {0, count}. Each rising edge of `hblank` moves exactly one unit, however long the pulse stays high, and `cpu_stall` is high while that unit moves.
- R9: Each finished unit decrements the count. The unit that finishes at count 0 leaves the control byte at 0xFF and ends the mode, and later `hblank` edges move nothing.
- R10: A control write with bit 7 = 0 while line-gap mode is armed disarms it without starting a copy. The control byte then reads 0x80 | count.
- R11: Register writes made while `cpu_stall` is high are ignored.
- R12: A request held without `mem_ready` keeps `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` stable. A completed read is followed by the write of that byte.
- R13: Indices 5–7 read 0xFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 src high, 1 src low, 2 dst high, 3 dst low, 4 control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback at `cfg_addr` (combinational) |
| hblank | input | 1 | Horizontal-blank level; its rising edge paces line-gap mode |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_write | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when a read handshakes |
| cpu_stall | output | 1 | High while the engine is copying |

## Verification
The bench targets five corner cases:
- **Unaligned pointers.** Low nibbles and destination bits outside the window are set, so a design that skipped the masking would read or write off the expected first address.
- **Window and address-space edges.** One transfer starts at destination 0x9FF0 with source 0xFFF0. A design that let the destination run on would write outside video memory, and one that mishandled the source wrap would report wrong pointers.
- **Line-gap counting.** The count is stepped down through zero, and a long `hblank` pulse checks that one edge yields one unit rather than a unit per cycle.
- **Cancel, invalid source and busy writes.** A disarm, a bad source and a control write made mid-transfer are each confirmed at the ports to have no effect.
- **Back-pressure.** Alternating `mem_ready` exposes any request that changes before it is accepted.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam logic [2:0] CFG_SRC_HI = 3'd0;
  localparam logic [2:0] CFG_SRC_LO = 3'd1;
  localparam logic [2:0] CFG_DST_HI = 3'd2;
  localparam logic [2:0] CFG_DST_LO = 3'd3;
  localparam logic [2:0] CFG_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_t;
endpackage

// File: rtl/vcd_mover.sv
module vcd_mover
  import vcd_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned UNIT_BYTES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*DW-1:0] src_in,
  input  logic [2*DW-1:0] dst_in,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] src_end,
  output logic [2*DW-1:0] dst_end,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int unsigned AW = 2 * DW;
  localparam int unsigned CW = (UNIT_BYTES > 1) ? $clog2(UNIT_BYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_BYTES - 1);

  mv_state_t       state_q;
  logic [AW-1:0]   src_q, dst_q;
  logic [CW-1:0]   idx_q;
  logic [DW-1:0]   byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      idx_q   <= '0;
      byte_q  <= '0;
    end else begin
      unique case (state_q)
        MV_IDLE: if (start) begin
          src_q   <= src_in;
          dst_q   <= dst_in;
          idx_q   <= '0;
          state_q <= MV_READ;
        end
        MV_READ: if (mem_ready) begin
          byte_q  <= mem_rdata;
          state_q <= MV_WRITE;
        end
        MV_WRITE: if (mem_ready) begin
          src_q   <= src_q + AW'(1);
          dst_q   <= dst_q + AW'(1);
          idx_q   <= idx_q + CW'(1);
          state_q <= (idx_q == LAST) ? MV_IDLE : MV_READ;
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != MV_IDLE);
  assign done      = (state_q == MV_WRITE) && mem_ready && (idx_q == LAST);
  assign src_end   = src_q + AW'(1);
  assign dst_end   = dst_q + AW'(1);
  assign mem_valid = busy;
  assign mem_write = (state_q == MV_WRITE);
  assign mem_addr  = mem_write ? dst_q : src_q;
  assign mem_wdata = byte_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata))); // R12
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && mem_ready) |=> (mem_valid && mem_write)); // R12
endmodule

// File: rtl/vcd_ctrl.sv
module vcd_ctrl
  import vcd_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned UNIT_BYTES = 16,
  parameter int unsigned VRAM_BASE  = 32'h8000,
  parameter int unsigned VRAM_SPAN  = 32'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic            hb_rise,
  input  logic            mv_busy,
  input  logic            mv_done,
  input  logic [2*DW-1:0] mv_src_end,
  input  logic [2*DW-1:0] mv_dst_end,
  output logic            mv_start,
  output logic [2*DW-1:0] mv_src,
  output logic [2*DW-1:0] mv_dst,
  output logic            cpu_stall
);
  localparam int unsigned AW = 2 * DW;
  localparam int unsigned CW = DW - 1;
  localparam logic [AW-1:0] ALIGN  = ~AW'(UNIT_BYTES - 1);
  localparam logic [AW-1:0] WINMSK = AW'(VRAM_SPAN - 1);
  localparam logic [AW-1:0] BASE   = AW'(VRAM_BASE);
  localparam logic [AW-1:0] LIMIT  = AW'(VRAM_BASE + VRAM_SPAN);

  logic [DW-1:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q;
  logic [CW-1:0] cnt_q;
  logic          idle_q, line_q, imm_q;
  logic          eng_busy, wr_ok, ctrl_wr, src_bad, start_imm, line_go;

  assign mv_src    = {src_hi_q, src_lo_q} & ALIGN;
  assign mv_dst    = ({dst_hi_q, dst_lo_q} & WINMSK & ALIGN) | BASE;
  assign src_bad   = (mv_src >= BASE) && (mv_src < LIMIT);
  assign eng_busy  = mv_busy | imm_q;
  assign wr_ok     = cfg_we & ~eng_busy;
  assign ctrl_wr   = wr_ok && (cfg_addr == CFG_CTRL);
  assign start_imm = ctrl_wr && !src_bad && !cfg_wdata[DW-1] && !line_q;
  assign line_go   = hb_rise && line_q && !eng_busy;
  assign mv_start  = start_imm | line_go | (imm_q & ~mv_busy);
  assign cpu_stall = eng_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
      cnt_q    <= '1;
      idle_q   <= 1'b1;
      line_q   <= 1'b0;
      imm_q    <= 1'b0;
    end else begin
      if (wr_ok) begin
        unique case (cfg_addr)
          CFG_SRC_HI: src_hi_q <= cfg_wdata;
          CFG_SRC_LO: src_lo_q <= cfg_wdata;
          CFG_DST_HI: dst_hi_q <= cfg_wdata;
          CFG_DST_LO: dst_lo_q <= cfg_wdata;
          CFG_CTRL: if (!src_bad) begin
            if (cfg_wdata[DW-1]) begin
              line_q <= 1'b1;
              cnt_q  <= cfg_wdata[CW-1:0];
              idle_q <= 1'b0;
            end else if (line_q) begin
              line_q <= 1'b0;
              idle_q <= 1'b1;
            end else begin
              imm_q  <= 1'b1;
              cnt_q  <= cfg_wdata[CW-1:0];
              idle_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (mv_done) begin
        {src_hi_q, src_lo_q} <= mv_src_end;
        {dst_hi_q, dst_lo_q} <= mv_dst_end;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == '0) begin
          idle_q <= 1'b1;
          imm_q  <= 1'b0;
          line_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (cfg_addr)
      CFG_SRC_HI: cfg_rdata = src_hi_q;
      CFG_SRC_LO: cfg_rdata = src_lo_q;
      CFG_DST_HI: cfg_rdata = dst_hi_q;
      CFG_DST_LO: cfg_rdata = dst_lo_q;
      CFG_CTRL:   cfg_rdata = {idle_q, cnt_q};
      default:    cfg_rdata = '1;
    endcase
  end

  AST_BAD_SRC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && src_bad && !line_q) |=> !cpu_stall); // R3
  AST_IMM_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    start_imm |=> cpu_stall); // R6
  AST_ONE_UNIT_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_done && !imm_q) |=> !mv_busy); // R8
endmodule

// File: rtl/vram_copy_engine.sv
module vram_copy_engine #(
  parameter int unsigned DW         = 8,
  parameter int unsigned UNIT_BYTES = 16,
  parameter int unsigned VRAM_BASE  = 32'h8000,
  parameter int unsigned VRAM_SPAN  = 32'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic            hblank,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            cpu_stall
);
  localparam int unsigned AW = 2 * DW;

  logic          hb_q, hb_rise;
  logic          mv_start, mv_busy, mv_done;
  logic [AW-1:0] mv_src, mv_dst, mv_src_end, mv_dst_end;

  always_ff @(posedge clk) begin
    if (!rst_n) hb_q <= 1'b0;
    else        hb_q <= hblank;
  end
  assign hb_rise = hblank & ~hb_q;

  vcd_ctrl #(.DW(DW), .UNIT_BYTES(UNIT_BYTES), .VRAM_BASE(VRAM_BASE), .VRAM_SPAN(VRAM_SPAN)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .hb_rise(hb_rise), .mv_busy(mv_busy), .mv_done(mv_done),
    .mv_src_end(mv_src_end), .mv_dst_end(mv_dst_end),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .cpu_stall(cpu_stall)
  );

  vcd_mover #(.DW(DW), .UNIT_BYTES(UNIT_BYTES)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(mv_start), .src_in(mv_src), .dst_in(mv_dst),
    .busy(mv_busy), .done(mv_done), .src_end(mv_src_end), .dst_end(mv_dst_end),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> ((mem_addr >= AW'(VRAM_BASE)) && (mem_addr < AW'(VRAM_BASE + VRAM_SPAN)))); // R4
  AST_STALL_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> cpu_stall); // R11
endmodule

// File: tb/vram_copy_engine_tb.sv
module vram_copy_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic        hblank = 1'b0;
  logic        mem_valid, mem_write, cpu_stall;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  int wr_total = 0;
  int rd_total = 0;
  int data_err = 0;
  int win_err = 0;
  int mark = 0;
  int cyc_total = 0;
  logic [15:0] last_rd = 16'h0;
  logic [15:0] wr_mark_addr = 16'h0;
  logic [15:0] rd_mark_addr = 16'h0;
  logic        bp_mode = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = pat(mem_addr);

  vram_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hblank(hblank), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cpu_stall(cpu_stall)
  );

  // memory model and monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (bp_mode) mem_ready = ~mem_ready;
    else         mem_ready = 1'b1;
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        if (wr_total == mark) wr_mark_addr = mem_addr;
        if (mem_wdata !== pat(last_rd)) data_err++;
        if (mem_addr < 16'h8000 || mem_addr >= 16'hA000) win_err++;
        wr_total++;
      end else begin
        if (rd_total == mark) rd_mark_addr = mem_addr;
        last_rd = mem_addr;
        rd_total++;
      end
    end
  end

  always @(negedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      $display("FAIL watchdog: run hung, actual %0d cycles, expected completion", cyc_total);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic rd_ptrs(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd_reg(3'd0, b0); rd_reg(3'd1, b1); rd_reg(3'd2, b2); rd_reg(3'd3, b3);
    v = {b0, b1, b2, b3};
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (cpu_stall && cyc < 20000) begin
      cyc++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input int hold, output logic saw_stall);
    @(negedge clk);
    hblank = 1'b1;
    @(negedge clk);
    saw_stall = cpu_stall;
    repeat (hold) @(negedge clk);
    hblank = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // src, dst, length code, first write, src after, dst after
  localparam logic [87:0] VEC [0:3] = '{
    {16'h1234, 16'hFF45, 8'h00, 16'h9F40, 16'h1240, 16'h9F50},
    {16'hC00F, 16'h0000, 8'h03, 16'h8000, 16'hC040, 16'h8040},
    {16'hA0F0, 16'h1ABC, 8'h01, 16'h9AB0, 16'hA110, 16'h9AD0},
    {16'hFFF0, 16'h9FF0, 8'h01, 16'h9FF0, 16'h0010, 16'h8010}
  };

  initial begin
    logic [7:0]  rb;
    logic [31:0] ptrs;
    logic        st;
    int          cyc, base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_ptrs(ptrs);
    chk("R1 pointers after reset", ptrs, 32'h0);
    rd_reg(3'd4, rb);
    chk("R1 control after reset", {24'h0, rb}, 32'hFF);
    chk("R1 stall/valid after reset", {30'h0, cpu_stall, mem_valid}, 32'h0);

    // immediate transfers from the vector table
    for (int i = 0; i < 4; i++) begin
      logic [15:0] s, d, fw, se, de;
      logic [7:0]  n;
      int units;
      {s, d, n, fw, se, de} = VEC[i];
      units = n + 1;
      base = wr_total;
      mark = wr_total;
      wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
      wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
      wr_reg(3'd4, n);
      wait_idle(cyc);
      chk($sformatf("R6 stall length vec%0d", i), cyc, 33 * units - 1);
      chk($sformatf("R5 byte count vec%0d", i), wr_total - base, units * 16);
      chk($sformatf("R2 first read vec%0d", i), {16'h0, rd_mark_addr}, {16'h0, s & 16'hFFF0});
      chk($sformatf("R4 first write vec%0d", i), {16'h0, wr_mark_addr}, {16'h0, fw});
      rd_ptrs(ptrs);
      chk($sformatf("R7 pointers after vec%0d", i), ptrs, {se, de});
      rd_reg(3'd4, rb);
      chk($sformatf("R5 control after vec%0d", i), {24'h0, rb}, 32'hFF);
    end
    chk("R5 data matches source", data_err, 0);
    chk("R4 writes inside window", win_err, 0);

    // R3 invalid source: neither immediate nor line-gap starts
    base = wr_total;
    wr_reg(3'd0, 8'h88); wr_reg(3'd1, 8'h00);
    wr_reg(3'd4, 8'h00);
    repeat (3) @(negedge clk);
    chk("R3 no stall on bad source", {31'h0, cpu_stall}, 32'h0);
    wr_reg(3'd4, 8'h83);
    rd_reg(3'd4, rb);
    chk("R3 control unchanged", {24'h0, rb}, 32'hFF);
    pulse(2, st);
    chk("R3 no bytes moved", wr_total - base, 0);

    // R8/R9 line-gap mode
    wr_reg(3'd0, 8'h40); wr_reg(3'd1, 8'h00);
    wr_reg(3'd2, 8'h81); wr_reg(3'd3, 8'h00);
    wr_reg(3'd4, 8'h82);
    rd_reg(3'd4, rb);
    chk("R8 armed control readback", {24'h0, rb}, 32'h02);
    base = wr_total;
    pulse(60, st);
    chk("R8 stall during unit", {31'h0, st}, 32'h1);
    chk("R8 long pulse moves one unit", wr_total - base, 16);
    rd_reg(3'd4, rb);
    chk("R9 count after unit 1", {24'h0, rb}, 32'h01);
    rd_ptrs(ptrs);
    chk("R7 pointers after line unit", ptrs, 32'h40108110);
    pulse(2, st);
    rd_reg(3'd4, rb);
    chk("R9 count after unit 2", {24'h0, rb}, 32'h00);
    pulse(2, st);
    rd_reg(3'd4, rb);
    chk("R9 wrap ends mode", {24'h0, rb}, 32'hFF);
    chk("R9 three units moved", wr_total - base, 48);
    pulse(2, st);
    chk("R9 edge after end moves nothing", wr_total - base, 48);

    // R10 disarm
    wr_reg(3'd0, 8'h20); wr_reg(3'd1, 8'h00);
    wr_reg(3'd4, 8'h85);
    base = wr_total;
    pulse(2, st);
    rd_reg(3'd4, rb);
    chk("R10 count before disarm", {24'h0, rb}, 32'h04);
    wr_reg(3'd4, 8'h00);
    repeat (2) @(negedge clk);
    rd_reg(3'd4, rb);
    chk("R10 disarmed readback", {24'h0, rb}, 32'h84);
    pulse(2, st);
    chk("R10 no copy after disarm", wr_total - base, 16);

    // R11 control write during an immediate transfer is ignored
    wr_reg(3'd0, 8'h30); wr_reg(3'd1, 8'h00);
    wr_reg(3'd2, 8'h82); wr_reg(3'd3, 8'h00);
    base = wr_total;
    wr_reg(3'd4, 8'h01);
    repeat (8) @(negedge clk);
    wr_reg(3'd4, 8'h85);
    wait_idle(cyc);
    chk("R11 byte count unaffected", wr_total - base, 32);
    rd_reg(3'd4, rb);
    chk("R11 control unaffected", {24'h0, rb}, 32'hFF);

    // R12 back-pressure
    bp_mode = 1'b1;
    wr_reg(3'd0, 8'h50); wr_reg(3'd1, 8'h00);
    wr_reg(3'd2, 8'h83); wr_reg(3'd3, 8'h00);
    base = wr_total;
    mark = wr_total;
    wr_reg(3'd4, 8'h00);
    wait_idle(cyc);
    bp_mode = 1'b0;
    chk("R12 bytes under back-pressure", wr_total - base, 16);
    chk("R12 first write under back-pressure", {16'h0, wr_mark_addr}, 32'h8300);
    chk("R12 data under back-pressure", data_err, 0);

    // R13 unused indices
    wr_reg(3'd5, 8'h12);
    rd_reg(3'd5, rb);
    chk("R13 unused index reads FF", {24'h0, rb}, 32'hFF);
    rd_ptrs(ptrs);
    chk("R13 write to unused index harmless", ptrs, 32'h50108310);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule